// File: doc/BRIEF.md
# CPU Address Window Decoder

This block sits between a processor's address path and the chip's target interfaces. It holds a bank of 21 programmable address windows and decides, for each presented 32-bit address, which target is addressed. The targets are SDRAM chip selects 0 to 3 (windows 0 to 3), device chip selects 0 to 3 (windows 4 to 7), the boot chip select (window 8), two PCI I/O windows (9 and 10) and eight PCI memory windows (11 to 18). Windows 19 and 20 are general device windows. A separate fixed 64 KB window covers the internal register space. Each window has a base register and a size register, both in 64 KB units. A window's open or closed state is one bit in a shared register, where a 1 means closed.

A PCI memory window also translates the address. The 64 KB page bits under the window's size mask are replaced by the window's low remap value. The upper 32 bits of a 64-bit outgoing address come from the window's high remap register, so a PCI target can lie above 4 GB. Software programs the windows through a simple write port with a combinational read port. A lookup port returns a registered hit flag, a target index and the translated address one cycle after the address is presented.

Top module: `cpu_win_decoder`

## Requirements
- R1: After reset every window is closed except window 8, which is open with base 0xFFF0 and size 0x000F, covering 0xFFF00000 to 0xFFFFFFFF. The shared disable register reads 0x1FFEFF. The internal-space register reads 0x00001400.
- R2: Register address w*4+f selects field f of window w: f=0 is the base (16 bits), f=1 the size (16 bits), f=2 the low remap (16 bits) and f=3 the high remap (32 bits). Address 84 holds the disable register (bit i closes window i) and address 85 the internal-space register. Writes read back unchanged. Remap fields exist only on windows 11 to 18; elsewhere they read 0 and writes to them are ignored.
- R3: An open window w matches address A when (A[31:16] ^ base) & ~size is zero. Base bits under the size mask are ignored.
- R4: A window whose disable bit is 1 never matches.
- R5: When several open windows match, the lowest-numbered one is reported. The internal space ranks below all 21 windows.
- R6: A size write whose value, read from bit 0 upward, is not a run of ones followed only by zeros is dropped, and the old size is kept.
- R7: For a hit in windows 11 to 18, the output address is {high remap, (A[31:16] & ~size) | (low remap & size), A[15:0]}. Every other hit returns A zero-extended to 64 bits.
- R8: The internal space matches when bits [19:0] of register 85, taken as address bits [35:16], equal {4'h0, A[31:16]}. Its target index is 21. Writes to register 85 change bits [23:0] only and keep bits [31:24].
- R9: Reading address 96+i returns window i's length in 64 KB units: size+1 when the window is open, 0 when it is closed.
- R10: The result appears on the first clock edge after a lookup is presented. A miss reports hit 0, index 0 and address 0. A register write made in the same cycle as a lookup is not seen by that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_idx | output | 5 | Index of the winning window (21 = internal space) |
| res_addr | output | 64 | Translated outgoing address |

## Verification
A register write and a lookup can land in the same cycle. This matters most when the write closes, moves or resizes the window that the lookup would hit. The bench issues both in one cycle against a window the address currently hits. It expects the result to reflect the old configuration, and then expects the next lookup of the same address to reflect the new one. The random phase also interleaves reprogramming and lookups back to back, so many lookups follow immediately after a write.

// File: rtl/cpu_win_decoder.sv
module cpu_win_decoder #(
  parameter int          NUM_WIN        = 21,
  parameter int          PCI_MEM_FIRST  = 11,
  parameter int          PCI_MEM_LAST   = 18,
  parameter int          BOOT_WIN       = 8,
  parameter logic [15:0] BOOT_BASE_RST  = 16'hFFF0,
  parameter logic [15:0] BOOT_SIZE_RST  = 16'h000F,
  parameter logic [31:0] INT_DECODE_RST = 32'h0000_1400,
  parameter int          RA_W           = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            lk_valid,
  input  logic [31:0]     lk_addr,
  output logic            res_valid,
  output logic            res_hit,
  output logic [4:0]      res_idx,
  output logic [63:0]     res_addr
);
  localparam int IDX_W    = 5;
  localparam int DIS_ADDR = NUM_WIN * 4;
  localparam int INT_ADDR = DIS_ADDR + 1;
  localparam int LEN_BASE = (1 << RA_W) - 32;

  logic [15:0]          base_w  [NUM_WIN];
  logic [15:0]          size_w  [NUM_WIN];
  logic [15:0]          rlo_w   [NUM_WIN];
  logic [31:0]          rhi_w   [NUM_WIN];
  logic [NUM_WIN-1:0]   win_hit;
  logic [NUM_WIN-1:0]   dis_q;
  logic [NUM_WIN*16-1:0] size_flat;
  logic [31:0]          int_q;

  function automatic logic legal_mask(input logic [15:0] v);
    return (v & (v + 16'd1)) == 16'd0;
  endfunction

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [15:0] base_q, size_q;
    logic        sel;
    assign sel = reg_we && (reg_addr[RA_W-1:2] == (RA_W-2)'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= (g == BOOT_WIN) ? BOOT_BASE_RST : 16'd0;
        size_q <= (g == BOOT_WIN) ? BOOT_SIZE_RST : 16'd0;
      end else if (sel) begin
        if (reg_addr[1:0] == 2'd0) base_q <= reg_wdata[15:0];
        if (reg_addr[1:0] == 2'd1 && legal_mask(reg_wdata[15:0])) size_q <= reg_wdata[15:0];
      end
    end

    if (g >= PCI_MEM_FIRST && g <= PCI_MEM_LAST) begin : g_remap
      logic [15:0] rlo_q;
      logic [31:0] rhi_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          rlo_q <= 16'd0;
          rhi_q <= 32'd0;
        end else if (sel) begin
          if (reg_addr[1:0] == 2'd2) rlo_q <= reg_wdata[15:0];
          if (reg_addr[1:0] == 2'd3) rhi_q <= reg_wdata;
        end
      end
      assign rlo_w[g] = rlo_q;
      assign rhi_w[g] = rhi_q;
    end else begin : g_plain
      assign rlo_w[g] = 16'd0;
      assign rhi_w[g] = 32'd0;
    end

    assign base_w[g]  = base_q;
    assign size_w[g]  = size_q;
    assign size_flat[g*16 +: 16] = size_q;
    assign win_hit[g] = !dis_q[g] && (((lk_addr[31:16] ^ base_q) & ~size_q) == 16'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q <= ~(NUM_WIN'(1) << BOOT_WIN);
      int_q <= INT_DECODE_RST;
    end else if (reg_we) begin
      if (reg_addr == RA_W'(DIS_ADDR)) dis_q <= reg_wdata[NUM_WIN-1:0];
      if (reg_addr == RA_W'(INT_ADDR)) int_q <= {int_q[31:24], reg_wdata[23:0]};
    end
  end

  logic [RA_W-3:0] rd_win;
  logic [RA_W-1:0] len_off;
  assign rd_win  = reg_addr[RA_W-1:2];
  assign len_off = reg_addr - RA_W'(LEN_BASE);

  always_comb begin
    reg_rdata = 32'd0;
    if (reg_addr < RA_W'(DIS_ADDR)) begin
      case (reg_addr[1:0])
        2'd0:    reg_rdata = {16'd0, base_w[rd_win]};
        2'd1:    reg_rdata = {16'd0, size_w[rd_win]};
        2'd2:    reg_rdata = {16'd0, rlo_w[rd_win]};
        default: reg_rdata = rhi_w[rd_win];
      endcase
    end else if (reg_addr == RA_W'(DIS_ADDR)) begin
      reg_rdata = 32'(dis_q);
    end else if (reg_addr == RA_W'(INT_ADDR)) begin
      reg_rdata = int_q;
    end else if (reg_addr >= RA_W'(LEN_BASE) && len_off < RA_W'(NUM_WIN)) begin
      for (int i = 0; i < NUM_WIN; i++)
        if (len_off == RA_W'(i) && !dis_q[i]) reg_rdata = {15'd0, {1'b0, size_w[i]} + 17'd1};
    end
  end

  logic              int_hit, sel_hit, sel_pci;
  logic [IDX_W-1:0]  sel_idx;
  logic [15:0]       sel_sz, sel_rlo;
  logic [31:0]       sel_rhi;
  logic [63:0]       xlat;

  assign int_hit = (int_q[19:16] == 4'd0) && (int_q[15:0] == lk_addr[31:16]);

  always_comb begin
    sel_hit = int_hit;
    sel_idx = IDX_W'(NUM_WIN);
    sel_pci = 1'b0;
    sel_sz  = 16'd0;
    sel_rlo = 16'd0;
    sel_rhi = 32'd0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        sel_hit = 1'b1;
        sel_idx = IDX_W'(i);
        sel_pci = (i >= PCI_MEM_FIRST) && (i <= PCI_MEM_LAST);
        sel_sz  = size_w[i];
        sel_rlo = rlo_w[i];
        sel_rhi = rhi_w[i];
      end
    end
  end

  assign xlat = sel_pci
    ? {sel_rhi, (lk_addr[31:16] & ~sel_sz) | (sel_rlo & sel_sz), lk_addr[15:0]}
    : {32'd0, lk_addr};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_addr  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && sel_hit;
      res_idx   <= (lk_valid && sel_hit) ? sel_idx : '0;
      res_addr  <= (lk_valid && sel_hit) ? xlat : '0;
    end
  end
endmodule

// File: rtl/cpu_win_decoder_chk.sv
module cpu_win_decoder_chk #(
  parameter int NUM_WIN       = 21,
  parameter int PCI_MEM_FIRST = 11,
  parameter int PCI_MEM_LAST  = 18
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  lk_valid,
  input logic [31:0]           lk_addr,
  input logic                  res_valid,
  input logic                  res_hit,
  input logic [4:0]            res_idx,
  input logic [63:0]           res_addr,
  input logic [NUM_WIN-1:0]    dis_q,
  input logic [NUM_WIN*16-1:0] size_flat
);
  logic is_pci;
  assign is_pci = (res_idx >= 5'(PCI_MEM_FIRST)) && (res_idx <= 5'(PCI_MEM_LAST));

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst) lk_valid |=> res_valid); // R10
  AST_IDLE: assert property (@(posedge clk) disable iff (rst) !lk_valid |=> !res_valid); // R10
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_idx == 5'd0 && res_addr == 64'd0)); // R10
  AST_HIT_VALID: assert property (@(posedge clk) disable iff (rst) res_hit |-> res_valid); // R10
  AST_CLOSED_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (res_hit && res_idx < 5'(NUM_WIN)) |-> ((($past(dis_q) >> res_idx) & NUM_WIN'(1)) == '0)); // R4
  AST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (res_hit && !is_pci) |-> (res_addr == {32'd0, $past(lk_addr)})); // R7
  AST_PCI_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (res_hit && is_pci) |-> (res_addr[15:0] == $past(lk_addr[15:0]))); // R7

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_sz
    AST_SIZE_MASK: assert property (@(posedge clk) disable iff (rst)
      ((size_flat[g*16 +: 16] & (size_flat[g*16 +: 16] + 16'd1)) == 16'd0)); // R6
  end
endmodule

bind cpu_win_decoder cpu_win_decoder_chk #(
  .NUM_WIN(NUM_WIN), .PCI_MEM_FIRST(PCI_MEM_FIRST), .PCI_MEM_LAST(PCI_MEM_LAST)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_addr(res_addr),
  .dis_q(dis_q), .size_flat(size_flat)
);

// File: tb/cpu_win_decoder_bench.sv
`timescale 1ns/1ps
module cpu_win_decoder_bench;
  localparam int NW = 21;
  localparam int PF = 11;
  localparam int PL = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit;
  logic [4:0]  res_idx;
  logic [63:0] res_addr;

  cpu_win_decoder u_cpu_win_decoder (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_idx(res_idx), .res_addr(res_addr)
  );

  always #10 clk = ~clk;

  logic [15:0] m_base [NW];
  logic [15:0] m_size [NW];
  logic [15:0] m_rlo  [NW];
  logic [31:0] m_rhi  [NW];
  logic [NW-1:0] m_dis;
  logic [31:0] m_int;
  logic        e_hit;
  logic [4:0]  e_idx;
  logic [63:0] e_addr;
  int checks = 0;
  int fails  = 0;

  function automatic logic legal(input logic [15:0] v);
    return (v & (v + 16'd1)) == 16'd0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(input logic [6:0] a, input logic [31:0] d);
    if (a < 7'd84) begin
      int w;
      w = int'(a[6:2]);
      case (a[1:0])
        2'd0: m_base[w] = d[15:0];
        2'd1: if (legal(d[15:0])) m_size[w] = d[15:0];
        2'd2: if (w >= PF && w <= PL) m_rlo[w] = d[15:0];
        default: if (w >= PF && w <= PL) m_rhi[w] = d;
      endcase
    end else if (a == 7'd84) m_dis = d[NW-1:0];
    else if (a == 7'd85) m_int = {m_int[31:24], d[23:0]};
  endtask

  task automatic predict(input logic [31:0] a);
    e_hit = 1'b0; e_idx = 5'd0; e_addr = 64'd0;
    for (int i = 0; i < NW; i++) begin
      if (!e_hit && !m_dis[i] && (((a[31:16] ^ m_base[i]) & ~m_size[i]) == 16'd0)) begin
        e_hit = 1'b1;
        e_idx = 5'(i);
        if (i >= PF && i <= PL)
          e_addr = {m_rhi[i], (a[31:16] & ~m_size[i]) | (m_rlo[i] & m_size[i]), a[15:0]};
        else
          e_addr = {32'd0, a};
      end
    end
    if (!e_hit && m_int[19:16] == 4'd0 && m_int[15:0] == a[31:16]) begin
      e_hit = 1'b1; e_idx = 5'd21; e_addr = {32'd0, a};
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_check(input string tag, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic look(input string tag, input logic [31:0] a);
    predict(a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check({tag, " hit"}, {63'd0, res_hit}, {63'd0, e_hit});
    check({tag, " idx"}, {59'd0, res_idx}, {59'd0, e_idx});
    check({tag, " addr"}, res_addr, e_addr);
  endtask

  task automatic wr_and_look(input logic [6:0] wa, input logic [31:0] wd, input logic [31:0] a);
    predict(a);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = wa; reg_wdata = wd;
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    reg_we = 1'b0; lk_valid = 1'b0;
    check("R10 same-cycle hit", {63'd0, res_hit}, {63'd0, e_hit});
    check("R10 same-cycle idx", {59'd0, res_idx}, {59'd0, e_idx});
    model_wr(wa, wd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) begin
      m_base[i] = 16'd0; m_size[i] = 16'd0; m_rlo[i] = 16'd0; m_rhi[i] = 32'd0;
    end
    m_base[8] = 16'hFFF0; m_size[8] = 16'h000F;
    m_dis = ~(NW'(1) << 8);
    m_int = 32'h0000_1400;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    rd_check("R1 boot base", 7'd32, 32'h0000FFF0);
    rd_check("R1 boot size", 7'd33, 32'h0000000F);
    rd_check("R1 disable reg", 7'd84, 32'h001FFEFF);
    rd_check("R1 internal reg", 7'd85, 32'h00001400);
    rd_check("R9 boot length", 7'd104, 32'h00000010);
    rd_check("R9 closed length", 7'd96, 32'h00000000);
    check("R10 idle valid", {63'd0, res_valid}, 64'd0);
    look("R1 reset vector", 32'hFFFF_FFFC);
    look("R4 closed at reset", 32'h0000_0100);
    look("R8 internal default", 32'h1400_0010);

    wr(7'd20, 32'h0000ABCD);
    rd_check("R2 base readback", 7'd20, 32'h0000ABCD);
    wr(7'd2, 32'h00001234);
    rd_check("R2 remap ignored off PCI", 7'd2, 32'h0);
    wr(7'd47, 32'h00000001);
    rd_check("R2 remap high readback", 7'd47, 32'h00000001);

    wr(7'd1, 32'h00000005);
    rd_check("R6 illegal size dropped", 7'd1, 32'h0);
    wr(7'd1, 32'h000000FF);
    rd_check("R6 legal size kept", 7'd1, 32'h000000FF);
    wr(7'd0, 32'h00001234);
    wr(7'd84, 32'h001FFEFE);
    look("R3 base bits under mask ignored", 32'h1200_0040);
    look("R3 outside window", 32'h1300_0040);
    rd_check("R9 open length", 7'd96, 32'h00000100);

    wr(7'd8, 32'h00001200); wr(7'd9, 32'h0000000F);
    wr(7'd84, 32'h001FFEFA);
    look("R5 lowest index wins", 32'h1205_0000);
    wr(7'd84, 32'h001FFEFB);
    look("R4 closed window skipped", 32'h1205_0000);

    wr(7'd44, 32'h00008000); wr(7'd45, 32'h000003FF); wr(7'd46, 32'h00001100);
    wr(7'd84, 32'h001FF6FB);
    look("R7 PCI remap", 32'h8012_3456);
    check("R7 PCI remap literal", res_addr, 64'h0000_0001_8100_3456);

    wr(7'd85, 32'hFFFF_2000);
    rd_check("R8 upper byte kept", 7'd85, 32'h00FF2000);
    look("R8 above 4GB no match", 32'h2000_0000);
    wr(7'd85, 32'h0000_3000);
    look("R8 internal moved", 32'h3000_ABCD);

    wr_and_look(7'd84, 32'h001FFFFB, 32'h8001_0000);
    look("R10 write seen next lookup", 32'h8001_0000);

    for (int n = 0; n < 400; n++) begin
      int op, w, k;
      op = int'($urandom % 6);
      w  = int'($urandom % NW);
      case (op)
        0: begin
          k = int'($urandom % 17);
          wr(7'(w*4), $urandom);
          wr(7'(w*4+1), ($urandom % 8 == 0) ? $urandom : 32'((32'd1 << k) - 1));
          if (w >= PF && w <= PL) begin
            wr(7'(w*4+2), $urandom);
            wr(7'(w*4+3), $urandom);
          end
        end
        1: wr(7'd84, $urandom);
        2: look("R3 random near window",
                {m_base[w] ^ (16'($urandom) & m_size[w]), 16'($urandom)});
        3: look("R5 random address", $urandom);
        4: begin
          if ($urandom % 4 == 0) wr(7'd85, $urandom & 32'h000F_FFFF);
          look("R8 random internal", {m_int[15:0], 16'($urandom)});
        end
        default: begin
          rd_check("R9 random length", 7'(96 + w),
                   m_dis[w] ? 32'd0 : 32'({1'b0, m_size[w]} + 17'd1));
          rd_check("R2 random size readback", 7'(w*4+1), {16'd0, m_size[w]});
        end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule